// File: doc/BRIEF.md
# 14-bit Programmable Interval Timer

This block is a host-programmed interval timer built around a 14-bit down-counter. The counter advances on a prescaled tick: a divide-by-ten stage turns every tenth pulse of the system clock enable into one timer tick. A small write port holds a low count byte and a high byte. The high byte carries the top six count bits and a two-bit waveform mode. A command register starts and stops the counter.

The counter output can take one of four waveforms from the same count sequence: a one-shot square wave, a repeating square wave, a one-shot pulse, or a repeating pulse. A start command given while the timer is running is held back and takes effect at the next terminal count, so the output never shows a partial period. Each terminal count sets a sticky flag. The flag drives the interrupt line and is cleared by a status read strobe. The timer output can also be gated onto a tone pin.

Top module: `interval_timer14`

## Requirements
- R1: While reset is applied and until the first command, `tmr_out` is 1, `irq` is 0 and `tone_out` is 0 when `tone_en` is 0.
- R2: One timer tick occurs on every tenth clock edge at which `sys_en` is 1, counting from reset. Without a tick the count does not move.
- R3: A started count of N (2..0x3FFF) gives a period of exactly N ticks. The count length is {reg2[5:0], reg1[7:0]}, where reg1 is at `wr_addr`=1 and reg2 at `wr_addr`=2. The mode is reg2[7:6].
- R4: A count length below 2 is loaded as 2.
- R5: Mode 1 is a continuous square wave. The output is high for ceil(N/2) ticks and low for floor(N/2) ticks, and the count reloads at each terminal count.
- R6: Mode 0 gives one square period (high for the first half, low for the second half), then stops with the output high.
- R7: Mode 2 drives the output low for one tick period ending at terminal count, then stops with the output high.
- R8: Mode 3 drives the output low for one tick period before every terminal count and reloads automatically.
- R9: The command is written as `wr_data[7:6]` at `wr_addr`=0. Command 3 while idle loads and starts at once. Command 3 while running captures the staged count and mode and applies them at the next terminal count.
- R10: Command 1 stops the timer at once, and the output returns high.
- R11: Command 2 stops a running timer at its next terminal count. When the timer is idle it has no effect.
- R12: Each terminal count sets a flag that drives `irq`. The flag is cleared by `stat_rd`, and a terminal count in the same cycle as the read wins.
- R13: `tone_out` equals `tmr_out` when `tone_en` is 1 and is 0 otherwise.
- R14: Command 0 and writes to `wr_addr`=3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_en | input | 1 | System clock enable feeding the prescaler |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Register select: 0 command, 1 count low, 2 count high and mode |
| wr_data | input | 8 | Host write data |
| stat_rd | input | 1 | Status read strobe, clears the terminal-count flag |
| tone_en | input | 1 | Gates the timer output onto the tone pin |
| tmr_out | output | 1 | Timer waveform output |
| irq | output | 1 | Sticky terminal-count interrupt |
| tone_out | output | 1 | Gated timer output |

## Verification
The assertions assume that host writes, the status strobe and the enable are synchronous to `clk` and are applied through one write per cycle. They also take as given that a command and a tick may coincide, and they define the result as the tick's effect followed by the command's. The stimulus changes every input on the falling edge. It mixes directed runs of each mode with long random phases, in which `sys_en` is dropped at random to stretch the tick spacing and counts are kept short so that many terminal counts, deferred reloads and stop commands fall inside the run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CMD_NOP     = 2'd0,
    CMD_HALT    = 2'd1,
    CMD_HALT_TC = 2'd2,
    CMD_START   = 2'd3
  } tmr_cmd_e;

  localparam logic [1:0] ADR_CMD = 2'd0;
  localparam logic [1:0] ADR_LO  = 2'd1;
  localparam logic [1:0] ADR_HI  = 2'd2;

  localparam int MODE_AUTO_BIT  = 0;
  localparam int MODE_PULSE_BIT = 1;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    tick = 1'b0;
    if (en) begin
      if (pc_q == LAST) begin
        pc_d = '0;
        tick = 1'b1;
      end else begin
        pc_d = pc_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/tmr_hostif.sv
module tmr_hostif
  import tmr_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  output logic          cmd_vld,
  output tmr_cmd_e      cmd,
  output logic [CW-1:0] stg_len,
  output logic [1:0]    stg_mode
);
  localparam int HI_BITS = CW - 8;

  logic [7:0] lo_q, lo_d, hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_en && wr_addr == ADR_LO) lo_d = wr_data;
    if (wr_en && wr_addr == ADR_HI) hi_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cmd_vld  = wr_en && (wr_addr == ADR_CMD);
  assign cmd      = tmr_cmd_e'(wr_data[7:6]);
  assign stg_len  = {hi_q[HI_BITS-1:0], lo_q};
  assign stg_mode = hi_q[7:6];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW      = 14,
  parameter int MIN_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_vld,
  input  tmr_cmd_e      cmd,
  input  logic [CW-1:0] stg_len,
  input  logic [1:0]    stg_mode,
  input  logic          stat_rd,
  output logic          run,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] len,
  output logic [1:0]    mode,
  output logic          pend,
  output logic          flag
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] LMIN = CW'(MIN_LEN);

  logic          run_q, run_d, pend_q, pend_d, stop_q, stop_d, flag_q, flag_d;
  logic [CW-1:0] cnt_q, cnt_d, len_q, len_d, nlen_q, nlen_d, clamp_len;
  logic [1:0]    mode_q, mode_d, nmode_q, nmode_d;
  logic          tc;

  assign clamp_len = (stg_len < LMIN) ? LMIN : stg_len;

  always_comb begin
    run_d   = run_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    mode_d  = mode_q;
    pend_d  = pend_q;
    nlen_d  = nlen_q;
    nmode_d = nmode_q;
    stop_d  = stop_q;
    tc      = 1'b0;
    // counting step
    if (tick && run_q) begin
      if (cnt_q <= ONE) begin
        tc = 1'b1;
        if (pend_q) begin
          len_d  = nlen_q;
          mode_d = nmode_q;
          cnt_d  = nlen_q;
          pend_d = 1'b0;
        end else if (stop_q || !mode_q[MODE_AUTO_BIT]) begin
          run_d  = 1'b0;
          stop_d = 1'b0;
        end else begin
          cnt_d = len_q;
        end
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
    // command applied after the step of the same cycle
    if (cmd_vld) begin
      unique case (cmd)
        CMD_HALT: begin
          run_d  = 1'b0;
          pend_d = 1'b0;
          stop_d = 1'b0;
        end
        CMD_HALT_TC: begin
          if (run_d) begin
            stop_d = 1'b1;
            pend_d = 1'b0;
          end
        end
        CMD_START: begin
          if (run_d) begin
            pend_d  = 1'b1;
            stop_d  = 1'b0;
            nlen_d  = clamp_len;
            nmode_d = stg_mode;
          end else begin
            run_d  = 1'b1;
            cnt_d  = clamp_len;
            len_d  = clamp_len;
            mode_d = stg_mode;
            pend_d = 1'b0;
            stop_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
    flag_d = tc | (flag_q & ~stat_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= LMIN;
      len_q   <= LMIN;
      mode_q  <= '0;
      pend_q  <= 1'b0;
      nlen_q  <= LMIN;
      nmode_q <= '0;
      stop_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      mode_q  <= mode_d;
      pend_q  <= pend_d;
      nlen_q  <= nlen_d;
      nmode_q <= nmode_d;
      stop_q  <= stop_d;
      flag_q  <= flag_d;
    end
  end

  assign run  = run_q;
  assign cnt  = cnt_q;
  assign len  = len_q;
  assign mode = mode_q;
  assign pend = pend_q;
  assign flag = flag_q;
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic          run,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] len,
  input  logic [1:0]    mode,
  output logic          wave
);
  logic [CW-1:0] half;
  logic          active_lvl;

  assign half = len >> 1;

  generate
    if (CW > 1) begin : g_lvl
      always_comb begin
        if (mode[MODE_PULSE_BIT]) active_lvl = (cnt != CW'(1));
        else                      active_lvl = (cnt > half);
      end
    end
  endgenerate

  assign wave = !run || active_lvl;
endmodule

// File: rtl/interval_timer14.sv
module interval_timer14
  import tmr_pkg::*;
#(
  parameter int CW      = 14,
  parameter int DIV     = 10,
  parameter int MIN_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_en,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       stat_rd,
  input  logic       tone_en,
  output logic       tmr_out,
  output logic       irq,
  output logic       tone_out
);
  logic [1:0]    rs_q;
  logic          rst_core_n;
  logic          tick;
  logic          cmd_vld;
  tmr_cmd_e      cmd;
  logic [CW-1:0] stg_len, cnt_w, len_w;
  logic [1:0]    stg_mode, mode_w;
  logic          run_w, pend_w, flag_w, wave_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  tmr_presc #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_core_n), .en(sys_en), .tick(tick)
  );

  tmr_hostif #(.CW(CW)) u_host (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_vld(cmd_vld), .cmd(cmd),
    .stg_len(stg_len), .stg_mode(stg_mode)
  );

  tmr_core #(.CW(CW), .MIN_LEN(MIN_LEN)) u_core (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .cmd_vld(cmd_vld),
    .cmd(cmd), .stg_len(stg_len), .stg_mode(stg_mode), .stat_rd(stat_rd),
    .run(run_w), .cnt(cnt_w), .len(len_w), .mode(mode_w),
    .pend(pend_w), .flag(flag_w)
  );

  tmr_wave #(.CW(CW)) u_wave (
    .run(run_w), .cnt(cnt_w), .len(len_w), .mode(mode_w), .wave(wave_w)
  );

  assign tmr_out  = wave_w;
  assign irq      = flag_w;
  assign tone_out = tone_en & wave_w;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CW      = 14,
  parameter int MIN_LEN = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cmd_vld,
  input logic [1:0]    cmd,
  input logic          run,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] len,
  input logic [1:0]    mode,
  input logic          pend,
  input logic          irq
);
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cmd_vld) |=> ($stable(cnt) && $stable(run))); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt >= CW'(1) && cnt <= len)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && cnt > CW'(1)) |=> (!run || cnt == $past(cnt) - CW'(1))); // R3
  AST_LEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (len >= CW'(MIN_LEN))); // R4
  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && cnt == CW'(1) && !pend && !mode[0] && !cmd_vld) |=> !run); // R6
  AST_HALT_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd == 2'd1) |=> !run); // R10
  AST_TC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && cnt == CW'(1)) |=> irq); // R12
endmodule

bind interval_timer14 tmr_checker #(.CW(CW), .MIN_LEN(MIN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .tick(tick), .cmd_vld(cmd_vld),
  .cmd(cmd), .run(run_w), .cnt(cnt_w), .len(len_w), .mode(mode_w),
  .pend(pend_w), .irq(irq)
);

// File: tb/test_interval_timer14.sv
`timescale 1ns/1ps
module test_interval_timer14;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sys_en, wr_en, stat_rd, tone_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       tmr_out, irq, tone_out;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cycles = 0;
  bit  done = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  interval_timer14 i_interval_timer14 (
    .clk(clk), .rst_n(rst_n), .sys_en(sys_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .stat_rd(stat_rd),
    .tone_en(tone_en), .tmr_out(tmr_out), .irq(irq), .tone_out(tone_out)
  );

  // behavioural model built from the requirements
  logic [1:0]  m_sync;
  int          m_pc;
  bit          m_run, m_pend, m_stop, m_flag;
  int          m_cnt, m_len, m_nlen;
  logic [1:0]  m_mode, m_nmode;
  logic [7:0]  m_lo, m_hi;

  function automatic bit exp_out();
    if (!m_run) return 1'b1;
    if (m_mode[1]) return (m_cnt != 1);
    return (m_cnt > (m_len / 2));
  endfunction

  function automatic int clamp2(int v);
    return (v < 2) ? 2 : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 2'b00; m_pc = 0; m_run = 0; m_pend = 0; m_stop = 0; m_flag = 0;
      m_cnt = 2; m_len = 2; m_nlen = 2; m_mode = 0; m_nmode = 0; m_lo = 0; m_hi = 0;
    end else begin
      if (m_sync[1]) begin
        bit tk, tc, r_run;
        int stg;
        tk = 0; tc = 0;
        if (sys_en) begin
          if (m_pc == 9) begin m_pc = 0; tk = 1; end
          else m_pc = m_pc + 1;
        end
        stg = clamp2({m_hi[5:0], m_lo});
        if (tk && m_run) begin
          if (m_cnt == 1) begin
            tc = 1;
            if (m_pend) begin
              m_len = m_nlen; m_mode = m_nmode; m_cnt = m_nlen; m_pend = 0;
            end else if (m_stop || !m_mode[0]) begin
              m_run = 0; m_stop = 0;
            end else m_cnt = m_len;
          end else m_cnt = m_cnt - 1;
        end
        r_run = m_run;
        if (wr_en && wr_addr == 2'd0) begin
          case (wr_data[7:6])
            2'd1: begin m_run = 0; m_pend = 0; m_stop = 0; end
            2'd2: if (r_run) begin m_stop = 1; m_pend = 0; end
            2'd3: if (r_run) begin
                    m_pend = 1; m_stop = 0; m_nlen = stg; m_nmode = m_hi[7:6];
                  end else begin
                    m_run = 1; m_cnt = stg; m_len = stg; m_mode = m_hi[7:6];
                    m_pend = 0; m_stop = 0;
                  end
            default: ;
          endcase
        end
        m_flag = tc | (m_flag & ~stat_rd);
        if (wr_en && wr_addr == 2'd1) m_lo = wr_data;
        if (wr_en && wr_addr == 2'd2) m_hi = wr_data;
      end
      m_sync = {m_sync[0], 1'b1};
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cycles++;
    check(tag, "tmr_out", tmr_out, exp_out());
    check("R12", "irq", irq, m_flag);
    check("R13", "tone_out", tone_out, tone_en & exp_out());
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int guard = 0;
    while (!done) begin
      @(posedge clk);
      guard++;
      if (guard > 190000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=%0d exp<%0d", guard, 190000);
        summary();
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; sys_en = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    stat_rd = 0; tone_en = 0;
    tag = "R1";
    run_n(3);
    rst_n = 1'b1;
    run_n(4);
    check("R1", "tmr_out idle", tmr_out, 1'b1);
    check("R1", "irq idle", irq, 1'b0);
    sys_en = 1'b1;
    tone_en = 1'b1;

    tag = "R14";
    wr(2'd3, 8'hFF);
    wr(2'd0, 8'h00);
    run_n(40);
    check("R14", "still idle", tmr_out, 1'b1);

    tag = "R3 R5";
    wr(2'd1, 8'd5);
    wr(2'd2, 8'h40);
    wr(2'd0, 8'hC0);
    run_n(60);
    check("R5", "high half at 3rd tick", tmr_out, 1'b1);
    run_n(200);

    tag = "R9 R8";
    wr(2'd1, 8'd4);
    wr(2'd2, 8'hC0);
    wr(2'd0, 8'hC0);
    run_n(240);
    stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
    run_n(20);

    tag = "R11";
    wr(2'd0, 8'h80);
    run_n(120);
    check("R11", "stopped high", tmr_out, 1'b1);
    wr(2'd0, 8'h80);
    run_n(20);

    tag = "R10";
    wr(2'd1, 8'h2C);
    wr(2'd2, 8'h41);
    wr(2'd0, 8'hC0);
    run_n(50);
    wr(2'd0, 8'h40);
    run_n(30);
    check("R10", "halted high", tmr_out, 1'b1);

    tag = "R4 R6";
    wr(2'd1, 8'd0);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hC0);
    run_n(60);

    tag = "R7";
    wr(2'd1, 8'd3);
    wr(2'd2, 8'h80);
    wr(2'd0, 8'hC0);
    run_n(60);
    stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
    run_n(5);

    tag = "R2";
    for (int i = 0; i < 30000; i++) begin
      int r;
      r = $urandom % 100;
      sys_en  = ($urandom % 4) != 0;
      stat_rd = ($urandom % 30) == 0;
      if (($urandom % 50) == 0) tone_en = ~tone_en;
      if (r < 5) begin
        logic [1:0] a;
        logic [7:0] d;
        a = 2'($urandom % 4);
        d = 8'($urandom);
        if (a == 2'd2) d[5:0] = (($urandom % 8) == 0) ? 6'($urandom % 2) : 6'd0;
        if (a == 2'd1) d = 8'($urandom % 40);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
      end else begin
        wr_en = 1'b0;
      end
      cyc();
    end
    wr_en = 0; stat_rd = 0;
    done = 1'b1;
    summary();
  end
endmodule